// File: doc/BRIEF.md
# Processor-Side Interrupt Interface

This block sits between an interrupt distributor and one processor core. The distributor presents its current best candidate (ID, originating CPU number and an 8-bit priority). The block filters that candidate through a programmable priority mask and a preemption test against the interrupt the core is already servicing. It raises `irq_o` toward the core only when the candidate would really be taken. Lower numbers mean more urgent. Software talks to the block through a small register port. A read of the acknowledge word claims the candidate: it is pushed onto an internal stack of active priorities, and `dist_ack_o` pulses so the distributor marks it active. An end-of-interrupt write pops it again, and the running priority falls back to whatever was serviced before.

The preemption test looks only at the group part of each priority. The binary point setting decides how many low-order bits are sub-priority and are left out of the comparison. Because the stack has a bounded depth, nesting stops when it is full.

The IRQ line is driven by a two-state machine. `IRQ_IDLE` moves to `IRQ_SIGNAL` on the *raise* transition, taken when signalling is enabled and the candidate is eligible at a clock edge. `IRQ_SIGNAL` returns to `IRQ_IDLE` on the *drop* transition, taken when that condition is false at an edge. The line therefore follows eligibility one cycle later.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset, `irq_o` is 0, the control, mask and binary point words read 0, and the running priority reads 0xFF.
- R2: Register byte offsets are: control 0x00 (bit 0 = signalling enable, other bits read 0), mask 0x04 (low 8 bits kept), binary point 0x08 (low 3 bits kept), acknowledge 0x0C, end-of-interrupt 0x10, running priority 0x14, highest pending 0x18, identification 0xFC (constant `IDENT`).
- R3: `irq_o` is 1 exactly one cycle after an edge at which the enable bit is 1, a candidate is valid, its priority is strictly less than the mask, the stack is not full, and the preemption test of R9 passes. Otherwise it is 0.
- R4: An acknowledge read while a candidate passes R3's conditions returns the ID in bits [9:0] and the CPU number in bits [12:10]. The CPU number is forced to 0 when the ID is 16 or more. The same cycle pulses `dist_ack_o`, and the running priority becomes the candidate's priority.
- R5: An acknowledge read with nothing eligible returns 1023 and changes no state.
- R6: A highest-pending read returns the candidate in the R4 format, or 1023 when no candidate is valid. It never changes state.
- R7: An end-of-interrupt write whose bits [9:0] equal the most recently acknowledged active ID pops it and pulses `dist_eoi_o` with that ID on `dist_eoi_id_o`. Any other ID, or a write when nothing is active, is ignored.
- R8: Running priority is 0xFF with nothing active, and otherwise the priority of the most recent active entry. After an end-of-interrupt it returns to the previous entry's priority.
- R9: With something active, a candidate preempts only if its priority bits above position `bpr` (bits [7:bpr+1]) are numerically lower than those of the running priority. A binary point of 7 therefore blocks all preemption.
- R10: With `STACK_DEPTH` entries active, no further interrupt can be acknowledged; the read returns 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_rd_en_i | input | 1 | Register read strobe |
| reg_wr_en_i | input | 1 | Register write strobe (not together with a read) |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the strobe cycle |
| dist_valid_i | input | 1 | Distributor presents a candidate |
| dist_id_i | input | 10 | Candidate interrupt ID |
| dist_cpu_i | input | 3 | CPU that raised a software interrupt |
| dist_prio_i | input | 8 | Candidate priority |
| dist_ack_o | output | 1 | Candidate claimed this cycle |
| dist_eoi_o | output | 1 | Active interrupt finished this cycle |
| dist_eoi_id_o | output | 10 | ID of the finished interrupt |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
The bench builds the block with `STACK_DEPTH` set to 3 instead of the default 4. This lets three nested acknowledges reach the full-stack refusal quickly. ID and priority widths stay at 10 and 8, so the 1023 spurious code and the 0xFF idle priority are exercised at their real values. Binary points of 0, 3 and 7 are used to show fine-grained preemption, coarse groups with equal group priority refusing preemption, and the no-preemption extreme.

// File: rtl/irq_cif_pkg.sv
package irq_cif_pkg;
    localparam int ADDR_W      = 8;
    localparam int DATA_W      = 32;
    localparam int BPR_W       = 3;
    localparam int SPURIOUS_ID = 1023;
    localparam int SOFT_IDS    = 16;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_MASK  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_BPT   = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_ACK   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_EOI   = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_RUN   = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_PEND  = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_IDENT = 8'hFC;

    typedef enum logic [0:0] {
        IRQ_IDLE   = 1'b0,
        IRQ_SIGNAL = 1'b1
    } irq_state_e;
endpackage

// File: rtl/irq_prio_stack.sv
module irq_prio_stack #(
    parameter int DEPTH  = 4,
    parameter int ID_W   = 10,
    parameter int PRIO_W = 8,
    localparam int DW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [ID_W-1:0]   push_id_i,
    input  logic [PRIO_W-1:0] push_prio_i,
    input  logic              pop_i,
    output logic [ID_W-1:0]   top_id_o,
    output logic [PRIO_W-1:0] top_prio_o,
    output logic [DW-1:0]     depth_o,
    output logic              full_o,
    output logic              empty_o
);
    logic [DW-1:0]     count;
    logic [ID_W-1:0]   id_mem   [DEPTH];
    logic [PRIO_W-1:0] prio_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (push_i)
            count <= count + DW'(1);
        else if (pop_i)
            count <= count - DW'(1);
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                id_mem[g]   <= '0;
                prio_mem[g] <= '0;
            end else if (push_i && count == DW'(g)) begin
                id_mem[g]   <= push_id_i;
                prio_mem[g] <= push_prio_i;
            end
        end
    end

    always_comb begin
        top_id_o   = '0;
        top_prio_o = '1;
        for (int k = 0; k < DEPTH; k++) begin
            if (count != '0 && DW'(k) == count - DW'(1)) begin
                top_id_o   = id_mem[k];
                top_prio_o = prio_mem[k];
            end
        end
    end

    assign depth_o = count;
    assign full_o  = (count == DW'(DEPTH));
    assign empty_o = (count == '0);

    // R10
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (count != DW'(DEPTH)));

    // R7
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (count != '0));
endmodule

// File: rtl/irq_preempt_chk.sv
module irq_preempt_chk
    import irq_cif_pkg::*;
#(
    parameter int PRIO_W = 8
) (
    input  logic              cand_valid_i,
    input  logic [PRIO_W-1:0] cand_prio_i,
    input  logic [PRIO_W-1:0] mask_i,
    input  logic [BPR_W-1:0]  bpr_i,
    input  logic [PRIO_W-1:0] run_prio_i,
    input  logic              any_active_i,
    input  logic              room_i,
    output logic              eligible_o
);
    localparam int SH_W = BPR_W + 1;

    logic [SH_W-1:0]   shamt;
    logic [PRIO_W-1:0] grp_mask;
    logic              below_mask;
    logic              preempts;

    assign shamt      = {1'b0, bpr_i} + SH_W'(1);
    assign grp_mask   = {PRIO_W{1'b1}} << shamt;
    assign below_mask = cand_prio_i < mask_i;
    assign preempts   = !any_active_i ||
                        ((cand_prio_i & grp_mask) < (run_prio_i & grp_mask));
    assign eligible_o = cand_valid_i && below_mask && preempts && room_i;
endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
    import irq_cif_pkg::*;
#(
    parameter int          STACK_DEPTH = 4,
    parameter int          ID_W        = 10,
    parameter int          CPU_W       = 3,
    parameter int          PRIO_W      = 8,
    parameter logic [31:0] IDENT       = 32'h0002_043B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_rd_en_i,
    input  logic              reg_wr_en_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              dist_valid_i,
    input  logic [ID_W-1:0]   dist_id_i,
    input  logic [CPU_W-1:0]  dist_cpu_i,
    input  logic [PRIO_W-1:0] dist_prio_i,
    output logic              dist_ack_o,
    output logic              dist_eoi_o,
    output logic [ID_W-1:0]   dist_eoi_id_o,
    output logic              irq_o
);
    localparam int DW    = $clog2(STACK_DEPTH + 1);
    localparam int PAD_W = DATA_W - CPU_W - ID_W;

    logic              ctrl_en;
    logic [PRIO_W-1:0] pmr;
    logic [BPR_W-1:0]  bpr;
    irq_state_e        state, state_nx;

    logic [ID_W-1:0]   top_id;
    logic [PRIO_W-1:0] top_prio;
    logic [DW-1:0]     depth;
    logic              full, empty;
    logic [PRIO_W-1:0] run_prio;
    logic              eligible, take;
    logic              do_ack, do_eoi;
    logic [CPU_W-1:0]  cpu_field;
    logic [DATA_W-1:0] cand_word;

    assign run_prio = empty ? {PRIO_W{1'b1}} : top_prio;

    irq_preempt_chk #(.PRIO_W(PRIO_W)) u_pre (
        .cand_valid_i (dist_valid_i),
        .cand_prio_i  (dist_prio_i),
        .mask_i       (pmr),
        .bpr_i        (bpr),
        .run_prio_i   (run_prio),
        .any_active_i (!empty),
        .room_i       (!full),
        .eligible_o   (eligible)
    );

    assign take   = ctrl_en && eligible;
    assign do_ack = reg_rd_en_i && (reg_addr_i == OFF_ACK) && take;
    assign do_eoi = reg_wr_en_i && (reg_addr_i == OFF_EOI) && !empty &&
                    (reg_wdata_i[ID_W-1:0] == top_id);

    irq_prio_stack #(.DEPTH(STACK_DEPTH), .ID_W(ID_W), .PRIO_W(PRIO_W)) u_stk (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (do_ack),
        .push_id_i   (dist_id_i),
        .push_prio_i (dist_prio_i),
        .pop_i       (do_eoi),
        .top_id_o    (top_id),
        .top_prio_o  (top_prio),
        .depth_o     (depth),
        .full_o      (full),
        .empty_o     (empty)
    );

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en <= 1'b0;
            pmr     <= '0;
            bpr     <= '0;
        end else if (reg_wr_en_i) begin
            unique case (reg_addr_i)
                OFF_CTRL: ctrl_en <= reg_wdata_i[0];
                OFF_MASK: pmr     <= reg_wdata_i[PRIO_W-1:0];
                OFF_BPT:  bpr     <= reg_wdata_i[BPR_W-1:0];
                default:  ;
            endcase
        end
    end

    // IRQ line state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= IRQ_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            IRQ_IDLE:   if (take)  state_nx = IRQ_SIGNAL;  // raise
            IRQ_SIGNAL: if (!take) state_nx = IRQ_IDLE;    // drop
            default:    state_nx = IRQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        irq_o         = (state == IRQ_SIGNAL);
        dist_ack_o    = do_ack;
        dist_eoi_o    = do_eoi;
        dist_eoi_id_o = do_eoi ? top_id : '0;
    end

    assign cpu_field = (dist_id_i < ID_W'(SOFT_IDS)) ? dist_cpu_i : '0;
    assign cand_word = {{PAD_W{1'b0}}, cpu_field, dist_id_i};

    always_comb begin
        reg_rdata_o = '0;
        if (reg_rd_en_i) begin
            case (reg_addr_i)
                OFF_CTRL:  reg_rdata_o = {{(DATA_W-1){1'b0}}, ctrl_en};
                OFF_MASK:  reg_rdata_o = DATA_W'(pmr);
                OFF_BPT:   reg_rdata_o = DATA_W'(bpr);
                OFF_ACK:   reg_rdata_o = take ? cand_word : DATA_W'(SPURIOUS_ID);
                OFF_RUN:   reg_rdata_o = DATA_W'(run_prio);
                OFF_PEND:  reg_rdata_o = dist_valid_i ? cand_word : DATA_W'(SPURIOUS_ID);
                OFF_IDENT: reg_rdata_o = IDENT;
                default:   reg_rdata_o = '0;
            endcase
        end
    end

    // R2
    bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd_en_i && reg_wr_en_i));

    // R3
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(ctrl_en && dist_valid_i && (dist_prio_i < pmr)));

    // R4
    ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dist_ack_o |=> (run_prio == $past(dist_prio_i)));

    // R5
    spurious_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en_i && reg_addr_i == OFF_ACK && !dist_ack_o) |=> $stable(depth));

    // R7
    eoi_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dist_eoi_o |=> (depth == $past(depth) - DW'(1)));
endmodule

// File: tb/irq_cpu_if_tb.sv
`timescale 1ns/1ps
module irq_cpu_if_tb;
    localparam int DEPTH = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        dvalid = 1'b0;
    logic [9:0]  did = '0;
    logic [2:0]  dcpu = '0;
    logic [7:0]  dprio = '0;
    logic        ack, eoi, irq;
    logic [9:0]  eoi_id;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_cpu_if #(.STACK_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_rd_en_i(rd), .reg_wr_en_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .dist_valid_i(dvalid), .dist_id_i(did), .dist_cpu_i(dcpu),
        .dist_prio_i(dprio), .dist_ack_o(ack), .dist_eoi_o(eoi),
        .dist_eoi_id_o(eoi_id), .irq_o(irq)
    );

    // behavioural reference model
    int m_en = 0, m_pmr = 0, m_bpr = 0;
    int m_prio_q[$];
    int m_id_q[$];
    bit m_irq = 0;

    function automatic bit m_elig();
        int sh;
        if (!m_en || !dvalid) return 0;
        if (int'(dprio) >= m_pmr) return 0;
        if (m_prio_q.size() >= DEPTH) return 0;
        if (m_prio_q.size() == 0) return 1;
        sh = m_bpr + 1;
        return (int'(dprio) >> sh) < (m_prio_q[$] >> sh);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_pmr = 0; m_bpr = 0; m_irq = 0;
            m_prio_q.delete(); m_id_q.delete();
        end else begin
            bit e;
            e = m_elig();
            if (wr) begin
                if (addr == 8'h00) m_en = int'(wdata[0]);
                if (addr == 8'h04) m_pmr = int'(wdata[7:0]);
                if (addr == 8'h08) m_bpr = int'(wdata[2:0]);
                if (addr == 8'h10 && m_id_q.size() > 0 &&
                    m_id_q[$] == int'(wdata[9:0])) begin
                    void'(m_id_q.pop_back());
                    void'(m_prio_q.pop_back());
                end
            end
            if (rd && addr == 8'h0C && e) begin
                m_id_q.push_back(int'(did));
                m_prio_q.push_back(int'(dprio));
            end
            m_irq = e;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // R3: line compared to the model on every clock
    always @(negedge clk) begin
        if (rst_n) check(irq == m_irq, "R3 irq vs model", int'(irq), int'(m_irq));
    end

    task automatic rd_chk(input logic [7:0] a, input int exp, input string req);
        @(negedge clk);
        rd = 1'b1; addr = a;
        #1;
        check(int'(rdata) == exp, req, int'(rdata), exp);
        if (a == 8'h0C)
            check(ack == (exp != 1023), {req, " ack pulse"}, int'(ack), int'(exp != 1023));
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wr_do(input logic [7:0] a, input logic [31:0] d,
                         input int exp_eoi, input string req);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        #1;
        if (a == 8'h10) begin
            check(int'(eoi) == exp_eoi, {req, " eoi pulse"}, int'(eoi), exp_eoi);
            if (exp_eoi == 1)
                check(eoi_id == d[9:0], {req, " eoi id"}, int'(eoi_id), int'(d[9:0]));
        end
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic present(input bit v, input int id, input int cpu, input int pr);
        @(negedge clk);
        dvalid = v; did = 10'(id); dcpu = 3'(cpu); dprio = 8'(pr);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1 check(irq == 1'b0, "R1 irq", int'(irq), 0);
        rd_chk(8'h00, 0, "R1 ctrl");
        rd_chk(8'h04, 0, "R1 mask");
        rd_chk(8'h08, 0, "R1 bpt");
        rd_chk(8'h14, 'hFF, "R1 running");
        rd_chk(8'h0C, 1023, "R5 ack idle");
        // R2 field widths and identification
        wr_do(8'h04, 32'h1F0, 0, "R2");
        rd_chk(8'h04, 'hF0, "R2 mask low bits");
        wr_do(8'h08, 32'hA, 0, "R2");
        rd_chk(8'h08, 2, "R2 bpt low bits");
        wr_do(8'h08, 32'h0, 0, "R2");
        wr_do(8'h00, 32'hFFFF_FFFE, 0, "R2");
        rd_chk(8'h00, 0, "R2 ctrl bit0 only");
        wr_do(8'h00, 32'h1, 0, "R2");
        rd_chk(8'h00, 1, "R2 ctrl enable");
        rd_chk(8'hFC, 'h0002_043B, "R2 ident");
        // R4 first acknowledge
        present(1, 40, 5, 'hA0);
        #1 check(irq == 1'b1, "R3 raised", int'(irq), 1);
        rd_chk(8'h18, 40, "R6 pending, cpu zero");
        rd_chk(8'h0C, 40, "R4 ack id 40");
        rd_chk(8'h14, 'hA0, "R8 running A0");
        rd_chk(8'h0C, 1023, "R9 equal group no preempt");
        // R4 software interrupt with CPU field, nested
        present(1, 3, 5, 'h80);
        rd_chk(8'h0C, 'h1403, "R4 ack soft id cpu 5");
        rd_chk(8'h14, 'h80, "R8 running 80");
        present(1, 50, 1, 'h80);
        rd_chk(8'h0C, 1023, "R5 spurious");
        rd_chk(8'h14, 'h80, "R5 running unchanged");
        rd_chk(8'h18, 50, "R6 pending 50");
        rd_chk(8'h14, 'h80, "R6 no state change");
        // R7 end of interrupt ordering
        wr_do(8'h10, 32'd40, 0, "R7 wrong id ignored");
        rd_chk(8'h14, 'h80, "R7 running kept");
        wr_do(8'h10, 32'd3, 1, "R7 eoi 3");
        rd_chk(8'h14, 'hA0, "R8 restored A0");
        wr_do(8'h10, 32'd40, 1, "R7 eoi 40");
        rd_chk(8'h14, 'hFF, "R8 idle");
        wr_do(8'h10, 32'd40, 0, "R7 empty ignored");
        present(0, 0, 0, 0);
        rd_chk(8'h18, 1023, "R6 none pending");
        // R3 strict mask
        wr_do(8'h04, 32'hA0, 0, "R3");
        present(1, 60, 0, 'hA0);
        #1 check(irq == 1'b0, "R3 equal to mask", int'(irq), 0);
        rd_chk(8'h0C, 1023, "R3 mask equal refused");
        present(1, 61, 0, 'h9F);
        rd_chk(8'h0C, 61, "R3 below mask taken");
        // R9 binary point
        wr_do(8'h08, 32'h7, 0, "R9");
        present(1, 62, 0, 'h00);
        rd_chk(8'h0C, 1023, "R9 bpt 7 blocks");
        wr_do(8'h08, 32'h3, 0, "R9");
        present(1, 63, 0, 'h90);
        rd_chk(8'h0C, 1023, "R9 same group 9");
        present(1, 64, 0, 'h8F);
        rd_chk(8'h0C, 64, "R9 lower group");
        rd_chk(8'h14, 'h8F, "R8 running 8F");
        // R10 full stack
        wr_do(8'h08, 32'h0, 0, "R10");
        present(1, 65, 0, 'h10);
        rd_chk(8'h0C, 65, "R10 third entry");
        present(1, 66, 0, 'h00);
        #1 check(irq == 1'b0, "R10 full no irq", int'(irq), 0);
        rd_chk(8'h0C, 1023, "R10 full refused");
        rd_chk(8'h14, 'h10, "R10 running kept");
        wr_do(8'h10, 32'd65, 1, "R7 pop 65");
        rd_chk(8'h14, 'h8F, "R8 back to 8F");
        wr_do(8'h10, 32'd64, 1, "R7 pop 64");
        rd_chk(8'h14, 'h9F, "R8 back to 9F");
        wr_do(8'h10, 32'd61, 1, "R7 pop 61");
        rd_chk(8'h14, 'hFF, "R8 idle again");
        // R3 enable bit
        present(1, 70, 0, 'h10);
        #1 check(irq == 1'b1, "R3 enabled", int'(irq), 1);
        wr_do(8'h00, 32'h0, 0, "R3");
        @(negedge clk);
        #1 check(irq == 1'b0, "R3 disabled", int'(irq), 0);
        rd_chk(8'h0C, 1023, "R5 disabled ack");
        rd_chk(8'h14, 'hFF, "R5 still idle");
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule